// File: doc/BRIEF.md
# Grain Keystream Generator

This block produces a cipher keystream with the two-register Grain construction. An 80-bit linear feedback register and an 80-bit nonlinear feedback register advance together. Each has its own feedback function, and a nonlinear filter that reads both registers yields one output bit per clock. The nonlinear register also takes one bit of the linear register into its feedback.

A one-cycle `start` pulse captures an 80-bit key and a 64-bit IV. The block then runs a keystream-free warm-up of 160 clocks while `busy` is high. During the warm-up the filter output is folded back into both feedbacks. After that it emits one keystream bit per clock and packs every eight bits into a byte, which it presents with a one-cycle `ks_valid` strobe. The byte stream runs until the next `start` or reset. Combining the keystream with data is left to the surrounding logic.

Top module: `grain_keystream`

## Requirements
- R1: After reset, `busy` and `ks_valid` are 0 and `ks_byte` is 0x00. Without a `start` pulse, `ks_valid` stays 0.
- R2: On `start`, key bit k loads nonlinear state bit b[k] and IV bit k loads linear state bit s[k] (k counted from the LSB). Linear state bits s[64] to s[79] load as 1.
- R3: Linear feedback: the new bit is s[0]^s[13]^s[23]^s[38]^s[51]^s[62]. The state shifts toward index 0 and the new bit enters at index 79.
- R4: Nonlinear feedback: the new bit is s[0] XOR the linear terms b[0,9,14,21,28,33,37,45,52,60,62] XOR the products b63b60, b37b33, b15b9, b60b52b45, b33b28b21, b63b45b28b9, b60b52b37b33, b63b60b21b15, b63b60b52b45b37, b33b28b21b15b9 and b52b45b37b33b28b21.
- R5: The output bit is b[1]^b[2]^b[4]^b[10]^b[31]^b[43]^b[56]^h. With x0..x4 = s[3], s[25], s[46], s[64], b[63], h = x1^x4^x0x3^x2x3^x3x4^x0x1x2^x0x2x3^x0x2x4^x1x2x4^x2x3x4.
- R6: After the `start` edge, `busy` stays high for exactly 160 cycles, during which the output bit is XORed into both feedbacks. `ks_valid` is never high while `busy` is high.
- R7: Keystream bits are packed least significant bit first: the earliest bit of each group of eight lands in `ks_byte[0]`. The first strobe comes 8 cycles after `busy` falls, and strobes recur every 8 cycles, each one cycle wide.
- R8: A `start` pulse while the keystream is running aborts the stream at once and restarts from the new key and IV.
- R9: A `start` pulse during warm-up restarts the warm-up from the new key and IV, with a full 160-cycle `busy` period.
- R10: `ks_byte` changes only together with a `ks_valid` strobe and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads key and IV and begins warm-up |
| key | input | 80 | Cipher key, sampled on `start` |
| iv | input | 64 | Initial value, sampled on `start` |
| busy | output | 1 | High during the warm-up phase |
| ks_valid | output | 1 | One-cycle strobe marking a new keystream byte |
| ks_byte | output | 8 | Most recent keystream byte, LSB is the earliest bit |

## Verification
The bench builds the core with its default warm-up length of 160 clocks, so every stream it checks follows the full initialisation. Its reference model regrows both registers as indexed bit sequences, which makes the exact warm-up length and the LSB-first packing directly comparable. Several key and IV patterns, including all-zero and all-one cases, are followed for sixteen bytes each. Restarts are then issued both mid-stream and mid-warm-up, which exercises the abort paths and the strobe spacing around them.

// File: rtl/grain_keystream.sv
`timescale 1ns/1ps
module grain_keystream #(
  parameter int INIT_CLOCKS = 160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [79:0] key,
  input  logic [63:0] iv,
  output logic        busy,
  output logic        ks_valid,
  output logic [7:0]  ks_byte
);
  localparam int CW = $clog2(INIT_CLOCKS);

  typedef enum logic [1:0] {IDLE, WARM, RUN} phase_t;
  phase_t phase;

  logic [79:0] s, b;
  logic [CW-1:0] cnt;
  logic [2:0] nbit;
  logic [6:0] acc;

  wire x0 = s[3], x1 = s[25], x2 = s[46], x3 = s[64], x4 = b[63];

  wire h = x1 ^ x4 ^ (x0 & x3) ^ (x2 & x3) ^ (x3 & x4) ^ (x0 & x1 & x2)
         ^ (x0 & x2 & x3) ^ (x0 & x2 & x4) ^ (x1 & x2 & x4) ^ (x2 & x3 & x4);

  wire z = b[1] ^ b[2] ^ b[4] ^ b[10] ^ b[31] ^ b[43] ^ b[56] ^ h;

  wire lfb = s[0] ^ s[13] ^ s[23] ^ s[38] ^ s[51] ^ s[62];

  wire nlin = b[0] ^ b[9] ^ b[14] ^ b[21] ^ b[28] ^ b[33] ^ b[37]
            ^ b[45] ^ b[52] ^ b[60] ^ b[62];

  wire nprod = (b[63] & b[60]) ^ (b[37] & b[33]) ^ (b[15] & b[9])
             ^ (b[60] & b[52] & b[45]) ^ (b[33] & b[28] & b[21])
             ^ (b[63] & b[45] & b[28] & b[9])
             ^ (b[60] & b[52] & b[37] & b[33])
             ^ (b[63] & b[60] & b[21] & b[15])
             ^ (b[63] & b[60] & b[52] & b[45] & b[37])
             ^ (b[33] & b[28] & b[21] & b[15] & b[9])
             ^ (b[52] & b[45] & b[37] & b[33] & b[28] & b[21]);

  wire nfb = s[0] ^ nlin ^ nprod;

  wire fold = (phase == WARM) & z;

  assign busy = (phase == WARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= IDLE;
      s        <= '0;
      b        <= '0;
      cnt      <= '0;
      nbit     <= '0;
      acc      <= '0;
      ks_valid <= 1'b0;
      ks_byte  <= '0;
    end else if (start) begin
      phase    <= WARM;
      b        <= key;
      s        <= {16'hFFFF, iv};
      cnt      <= '0;
      nbit     <= '0;
      acc      <= '0;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= 1'b0;
      if (phase != IDLE) begin
        s <= {lfb ^ fold, s[79:1]};
        b <= {nfb ^ fold, b[79:1]};
      end
      if (phase == WARM) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(INIT_CLOCKS - 1)) phase <= RUN;
      end
      if (phase == RUN) begin
        nbit <= nbit + 1'b1;
        acc  <= {z, acc[6:1]};
        if (nbit == 3'd7) begin
          ks_byte  <= {z, acc};
          ks_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/grain_keystream_chk.sv
`timescale 1ns/1ps
module grain_keystream_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       ks_valid,
  input logic [7:0] ks_byte
);
  a_r6_no_strobe_in_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ks_valid);

  a_r7_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |=> !ks_valid);

  a_r8_start_enters_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !ks_valid));

  a_r1_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  a_r10_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ks_byte) |-> ks_valid);
endmodule

bind grain_keystream grain_keystream_chk chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .ks_valid(ks_valid), .ks_byte(ks_byte)
);

// File: tb/grain_keystream_test.sv
`timescale 1ns/1ps
module grain_keystream_test;
  localparam int NB = 16;
  localparam int WARM = 160;
  localparam int LEN = 80 + WARM + 8 * NB;

  logic clk = 0, rst_n = 0, start = 0;
  logic [79:0] key = '0;
  logic [63:0] iv = '0;
  logic busy, ks_valid;
  logic [7:0] ks_byte;

  always #10 clk = ~clk;

  grain_keystream uut (.clk(clk), .rst_n(rst_n), .start(start), .key(key),
    .iv(iv), .busy(busy), .ks_valid(ks_valid), .ks_byte(ks_byte));

  int checks = 0, errors = 0, popped = 0;
  int cyc = 0, last_v = -1, fall_cyc = -1000;
  logic prev_busy = 0;
  logic [7:0] held = '0;
  logic [7:0] expq[$];
  bit done = 0;

  bit sv[0:LEN-1];
  bit bv[0:LEN-1];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_ref(logic [79:0] k, logic [63:0] v);
    for (int i = 0; i < 80; i++) begin
      bv[i] = k[i];
      sv[i] = (i < 64) ? v[i] : 1'b1;
    end
    for (int t = 0; t < WARM + 8 * NB; t++) begin
      bit a0, a1, a2, a3, a4, hh, zz, ln, nn;
      a0 = sv[t+3]; a1 = sv[t+25]; a2 = sv[t+46]; a3 = sv[t+64]; a4 = bv[t+63];
      hh = a1 ^ a4 ^ (a0 & a3) ^ (a2 & a3) ^ (a3 & a4) ^ (a0 & a1 & a2)
         ^ (a0 & a2 & a3) ^ (a0 & a2 & a4) ^ (a1 & a2 & a4) ^ (a2 & a3 & a4);
      zz = hh ^ bv[t+1] ^ bv[t+2] ^ bv[t+4] ^ bv[t+10] ^ bv[t+31] ^ bv[t+43] ^ bv[t+56];
      ln = sv[t] ^ sv[t+13] ^ sv[t+23] ^ sv[t+38] ^ sv[t+51] ^ sv[t+62];
      nn = sv[t] ^ bv[t] ^ bv[t+9] ^ bv[t+14] ^ bv[t+21] ^ bv[t+28] ^ bv[t+33]
         ^ bv[t+37] ^ bv[t+45] ^ bv[t+52] ^ bv[t+60] ^ bv[t+62]
         ^ (bv[t+63] & bv[t+60]) ^ (bv[t+37] & bv[t+33]) ^ (bv[t+15] & bv[t+9])
         ^ (bv[t+60] & bv[t+52] & bv[t+45]) ^ (bv[t+33] & bv[t+28] & bv[t+21])
         ^ (bv[t+63] & bv[t+45] & bv[t+28] & bv[t+9])
         ^ (bv[t+60] & bv[t+52] & bv[t+37] & bv[t+33])
         ^ (bv[t+63] & bv[t+60] & bv[t+21] & bv[t+15])
         ^ (bv[t+63] & bv[t+60] & bv[t+52] & bv[t+45] & bv[t+37])
         ^ (bv[t+33] & bv[t+28] & bv[t+21] & bv[t+15] & bv[t+9])
         ^ (bv[t+52] & bv[t+45] & bv[t+37] & bv[t+33] & bv[t+28] & bv[t+21]);
      if (t < WARM) begin
        sv[t+80] = ln ^ zz;
        bv[t+80] = nn ^ zz;
      end else begin
        sv[t+80] = ln;
        bv[t+80] = nn;
        sv[t] = zz;
      end
    end
    expq.delete();
    for (int j = 0; j < NB; j++) begin
      logic [7:0] by;
      for (int q = 0; q < 8; q++) by[q] = sv[WARM + 8 * j + q];
      expq.push_back(by);
    end
  endtask

  task automatic launch(logic [79:0] k, logic [63:0] v);
    build_ref(k, v);
    @(posedge clk); #2;
    key = k; iv = v; start = 1; last_v = -1; popped = 0;
    @(posedge clk); #2;
    start = 0;
  endtask

  task automatic measure_busy(string req);
    int n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    check(n == WARM, req, n, WARM);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_busy && !busy) fall_cyc = cyc;
      prev_busy = busy;
      if (ks_valid) begin
        check(!busy, "R6 strobe during warm-up", busy, 0);
        if (last_v >= 0) check(cyc - last_v == 8, "R7 strobe spacing", cyc - last_v, 8);
        else check(cyc - fall_cyc == 8, "R7 first strobe delay", cyc - fall_cyc, 8);
        last_v = cyc;
        held = ks_byte;
        if (expq.size() != 0) begin
          logic [7:0] e;
          e = expq.pop_front();
          popped++;
          check(ks_byte == e, "R2 R3 R4 R5 R7 keystream byte", ks_byte, e);
        end
      end else if (last_v >= 0 && cyc - last_v == 3) begin
        check(ks_byte == held, "R10 byte hold", ks_byte, held);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(ks_valid == 0, "R1 reset strobe", ks_valid, 0);
    check(ks_byte == 0, "R1 reset byte", ks_byte, 0);
    @(posedge clk); #2 rst_n = 1;
    begin
      int seen = 0;
      repeat (30) begin @(negedge clk); if (ks_valid || busy) seen++; end
      check(seen == 0, "R1 idle without start", seen, 0);
    end

    launch({10{8'h44}}, {8{8'h55}});
    measure_busy("R6 warm-up length");
    drain();

    launch('0, '0);
    measure_busy("R6 warm-up length zero key");
    drain();

    launch({80{1'b1}}, {64{1'b1}});
    drain();

    launch(80'h0123456789abcdef1234, 64'h0123456789abcdef);
    drain();

    // R8: abort after five bytes of a running stream
    launch(80'hfeedfacecafebeef0f0f, 64'h1122334455667788);
    while (popped < 5) @(negedge clk);
    launch(80'h00000000000000000001, 64'h8000000000000000);
    measure_busy("R8 restart warm-up length");
    drain();
    check(popped == NB, "R8 restarted stream complete", popped, NB);

    // R9: restart during warm-up
    launch(80'h13579bdf02468ace1357, 64'hdeadbeef01234567);
    repeat (50) @(negedge clk);
    launch(80'h2468ace013579bdf2468, 64'h0badf00d76543210);
    measure_busy("R9 restarted warm-up length");
    drain();
    check(popped == NB, "R9 stream after warm-up restart", popped, NB);

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule